// File: doc/BRIEF.md
# Bit set, clear and test engine

This block carries out single-bit instructions against a byte-wide data space of 256 locations. A decoder upstream hands it an already-decoded request: the kind of operation (force a bit to one, force it to zero, or test it and branch), a three-bit index, a one-bit polarity for tests, the byte address taken from the operand after the opcode, a signed branch displacement, and the address of the instruction that follows. The data memory sits outside the block behind a simple synchronous port, with read data valid on the cycle after a read strobe.

Set and clear run as a read followed on the next cycle by a write of the same byte, with only the indexed bit altered. Test-and-branch reads the byte, compares the chosen bit with the polarity, and reports a taken flag plus a 12-bit branch target. It never writes. A request is accepted only when the engine is idle. The result stays on the outputs until the next accepted request.

Top module: `bitop_engine`

## Requirements
- R1: Out of reset, `busy`, `done`, `taken`, `mem_rd` and `mem_wr` are all low and `target` is zero.
- R2: A set request (`op` = 2'b00) reads the addressed byte. One cycle later it writes the same address with the bit numbered `bit_idx` (0 = LSB) forced to one and every other bit unchanged.
- R3: A clear request (`op` = 2'b01) follows the same read-then-write order and forces the indexed bit to zero, leaving the other bits as read.
- R4: Every address from 0 to 255 and every bit index from 0 to 7 can be set and cleared. No location other than the addressed one is ever modified.
- R5: A test request (`op` = 2'b10) raises `taken` when the indexed bit equals `pol`: `pol` = 1 branches on a one bit and `pol` = 0 branches on a zero bit.
- R6: For a test, `target` = (`next_pc` + sign-extended `disp` + 1) mod 4096. This spans -127 (`disp` = 8'h80) to +128 (`disp` = 8'h7F) around the next instruction.
- R7: A test request performs exactly one read and no write.
- R8: An accepted start is sampled at a clock edge. `busy` is high from the next cycle until the end of the `done` cycle. `done` is a single-cycle pulse in the third cycle after that edge.
- R9: A start pulse while `busy` is high is ignored. It causes no extra memory access, and the running operation keeps its original operands.
- R10: A start with `op` = 2'b11 is ignored: `busy` stays low and there is no memory access.
- R11: A set or clear finishes with `taken` low. `taken` and `target` hold their values while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when idle |
| op | input | 2 | 00 set, 01 clear, 10 test-and-branch, 11 reserved |
| bit_idx | input | 3 | Bit number within the byte |
| pol | input | 1 | Test polarity: 1 branch when the bit is one, 0 branch when it is zero |
| addr | input | 8 | Data-space byte address |
| disp | input | 8 | Signed branch displacement |
| next_pc | input | 12 | Address of the next instruction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision of the last test |
| target | output | 12 | Branch destination of the last test |
| mem_addr | output | 8 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |

## Verification
Random sets, clears and tests over the whole address and bit range run against a shadow copy of memory. This shows whether the right bit moves and whether neighbouring bits and bytes are left alone. Directed cases cover the lowest and highest bit and address, setting a bit that is already set, both polarities against both bit values, and the two displacement extremes with program addresses near 0 and 4095. Together these separate sign-extension and wrap errors from off-by-one errors. A start held high through a whole operation with altered operands, and a start with the reserved code, show whether stray requests are accepted.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   typedef enum logic [1:0] {
      OP_SET = 2'b00,
      OP_CLR = 2'b01,
      OP_TST = 2'b10,
      OP_RSV = 2'b11
   } bitop_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RD   = 2'b01,
      ST_EXEC = 2'b10,
      ST_FIN  = 2'b11
   } bitop_state_e;
endpackage

// File: rtl/bitop_modify.sv
module bitop_modify #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [IDX_W-1:0]  idx,
   input  logic              set_val,
   output logic [DATA_W-1:0] wdata,
   output logic              bit_val
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign wdata[i] = (idx == IDX_W'(i)) ? set_val : rdata[i];
   end

   assign bit_val = rdata[idx];

   // R2 R3: the rewritten byte differs from the read byte in at most one bit
   always_comb begin
      p_one_bit_changed_r2: assert ($countones(wdata ^ rdata) <= 1);
   end
endmodule

// File: rtl/bitop_target.sv
module bitop_target #(
   parameter int PC_W   = 12,
   parameter int DISP_W = 8
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic [PC_W-1:0]   target
);
   logic [PC_W-1:0] disp_ext;

   if (PC_W > DISP_W) begin : g_sext
      assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
   end else begin : g_trunc
      assign disp_ext = disp[PC_W-1:0];
   end

   assign target = pc + disp_ext + PC_W'(1);
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
   import bitop_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int PC_W   = 12,
   parameter int DISP_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  bitop_e            op,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              pol,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DISP_W-1:0] disp,
   input  logic [PC_W-1:0]   next_pc,
   input  logic              bit_val,
   input  logic [PC_W-1:0]   target_in,
   output bitop_e            op_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [DISP_W-1:0] disp_q,
   output logic [PC_W-1:0]   pc_q,
   output logic              busy,
   output logic              done,
   output logic              taken,
   output logic [PC_W-1:0]   target,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr
);
   bitop_state_e      state_q;
   logic              pol_q;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;

   assign accept = (state_q == ST_IDLE) && start && (op != OP_RSV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_SET;
         idx_q   <= '0;
         pol_q   <= 1'b0;
         addr_q  <= '0;
         disp_q  <= '0;
         pc_q    <= '0;
         taken   <= 1'b0;
         target  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  op_q    <= op;
                  idx_q   <= bit_idx;
                  pol_q   <= pol;
                  addr_q  <= addr;
                  disp_q  <= disp;
                  pc_q    <= next_pc;
                  state_q <= ST_RD;
               end
            end
            ST_RD:   state_q <= ST_EXEC;
            ST_EXEC: begin
               state_q <= ST_FIN;
               if (op_q == OP_TST) begin
                  taken  <= (bit_val == pol_q);
                  target <= target_in;
               end else begin
                  taken  <= 1'b0;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_FIN);
   assign mem_rd   = (state_q == ST_RD);
   assign mem_wr   = (state_q == ST_EXEC) && (op_q != OP_TST);
   assign mem_addr = addr_q;

   // R8: completion is a single-cycle pulse raised while still busy
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R9: a running operation keeps going and keeps its address
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(mem_addr)));
   // R10: reserved code does not start anything
   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op == OP_RSV) |=> !busy);
   // R11: results hold while idle
   p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!busy) && !busy) |-> ($stable(taken) && $stable(target)));
endmodule

// File: rtl/bitop_engine.sv
module bitop_engine
   import bitop_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int PC_W   = 12,
   parameter int DISP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   input  logic              pol,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DISP_W-1:0] disp,
   input  logic [PC_W-1:0]   next_pc,
   output logic              busy,
   output logic              done,
   output logic              taken,
   output logic [PC_W-1:0]   target,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(DATA_W);

   if ((DATA_W < 2) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_chk_data
      $error("DATA_W must be a power of two of at least 2");
   end
   if ((DISP_W < 2) || (PC_W < 2)) begin : g_chk_pc
      $error("PC_W and DISP_W must be at least 2");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("ADDR_W must be positive");
   end

   bitop_e            op_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DISP_W-1:0] disp_q;
   logic [PC_W-1:0]   pc_q;
   logic              bit_val;
   logic [PC_W-1:0]   target_c;

   bitop_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W),
      .DISP_W(DISP_W), .IDX_W(IDX_W)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op       (bitop_e'(op)),
      .bit_idx  (bit_idx),
      .pol      (pol),
      .addr     (addr),
      .disp     (disp),
      .next_pc  (next_pc),
      .bit_val  (bit_val),
      .target_in(target_c),
      .op_q     (op_q),
      .idx_q    (idx_q),
      .disp_q   (disp_q),
      .pc_q     (pc_q),
      .busy     (busy),
      .done     (done),
      .taken    (taken),
      .target   (target),
      .mem_addr (mem_addr),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr)
   );

   bitop_modify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) modify_i (
      .rdata  (mem_rdata),
      .idx    (idx_q),
      .set_val(op_q == OP_SET),
      .wdata  (mem_wdata),
      .bit_val(bit_val)
   );

   bitop_target #(.PC_W(PC_W), .DISP_W(DISP_W)) target_i (
      .pc    (pc_q),
      .disp  (disp_q),
      .target(target_c)
   );

   // R2 R3: each write follows a read of the same byte on the previous cycle
   p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));
   // R7: a test read is never followed by a write
   p_test_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && op_q == OP_TST) |=> !mem_wr);
   // R4: read and write strobes never overlap
   p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
endmodule

// File: tb/bitop_engine_tb_top.sv
module bitop_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [2:0]  bit_idx = 3'd0;
   logic        pol = 1'b0;
   logic [7:0]  addr = 8'd0;
   logic [7:0]  disp = 8'd0;
   logic [11:0] next_pc = 12'd0;
   logic        busy, done, taken;
   logic [11:0] target;
   logic [7:0]  mem_addr, mem_wdata;
   logic [7:0]  mem_rdata = 8'd0;
   logic        mem_rd, mem_wr;

   logic [7:0]  mem    [256];
   logic [7:0]  shadow [256];
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   int          total = 0;
   int          bad = 0;

   always #2 clk = ~clk;

   bitop_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_idx(bit_idx),
      .pol(pol), .addr(addr), .disp(disp), .next_pc(next_pc),
      .busy(busy), .done(done), .taken(taken), .target(target),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_wr) begin
         mem[mem_addr] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd) begin
         mem_rdata <= mem[mem_addr];
         rd_cnt <= rd_cnt + 1;
      end
   end

   function automatic logic [11:0] exp_target(logic [11:0] pc, logic [7:0] d);
      return pc + {{4{d[7]}}, d} + 12'd1;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One operation; with noise set, start stays high with other operands while busy.
   task automatic run_op(logic [1:0] o, logic [2:0] b, logic p, logic [7:0] a,
                         logic [7:0] d, logic [11:0] pc, bit noise);
      int  w0, r0;
      logic exp_tk;
      logic [11:0] exp_tg;
      logic [11:0] prev_tg;
      @(negedge clk);
      op = o; bit_idx = b; pol = p; addr = a; disp = d; next_pc = pc; start = 1'b1;
      w0 = wr_cnt; r0 = rd_cnt; prev_tg = target;
      @(negedge clk);
      if (noise) begin
         addr = a ^ 8'h5A; bit_idx = ~b; op = 2'b00; disp = ~d;
      end else start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R8 busy after start", {busy, done}, 2);
      @(negedge clk);
      chk(busy === 1'b1 && done === 1'b0, "R8 busy mid", {busy, done}, 2);
      @(negedge clk);
      chk(busy === 1'b1 && done === 1'b1, "R8 done cycle", {busy, done}, 3);
      if (o == 2'b10) begin
         exp_tk = (shadow[a][b] == p);
         exp_tg = exp_target(pc, d);
         chk(taken === exp_tk, "R5 taken", taken, exp_tk);
         chk(target === exp_tg, "R6 target", target, exp_tg);
         chk(wr_cnt == w0, "R7 no write", wr_cnt - w0, 0);
         chk(rd_cnt == r0 + 1, "R7 one read", rd_cnt - r0, 1);
      end else begin
         if (o == 2'b00) shadow[a][b] = 1'b1;
         else shadow[a][b] = 1'b0;
         exp_tg = prev_tg;
         chk(mem[a] === shadow[a], (o == 2'b00) ? "R2 set byte" : "R3 clear byte",
             mem[a], shadow[a]);
         chk(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R2 one read one write",
             (wr_cnt - w0) * 16 + (rd_cnt - r0), 17);
         chk(taken === 1'b0, "R11 taken low after set/clear", taken, 0);
      end
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b0 && done === 1'b0, "R8 idle after done", {busy, done}, 0);
      if (noise)
         chk(wr_cnt - w0 <= 1 && rd_cnt == r0 + 1, "R9 start while busy ignored",
             rd_cnt - r0, 1);
      exp_tk = taken;
      @(negedge clk);
      chk(busy === 1'b0 && taken === exp_tk && target === exp_tg,
          "R11 result held", {taken, target}, {exp_tk, exp_tg});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int w0, r0;
      void'($urandom(32'h0BD5_1234));
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'($urandom);
         shadow[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      chk(busy === 0 && done === 0 && taken === 0 && mem_rd === 0 && mem_wr === 0
          && target === 12'd0, "R1 reset state",
          {busy, done, taken, mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run_op(2'b00, 3'd0, 1'b0, 8'h00, 8'h00, 12'h000, 1'b0);
      run_op(2'b00, 3'd7, 1'b0, 8'hFF, 8'h00, 12'h000, 1'b0);
      run_op(2'b00, 3'd7, 1'b0, 8'hFF, 8'h00, 12'h000, 1'b0); // already set
      run_op(2'b01, 3'd0, 1'b0, 8'h00, 8'h00, 12'h000, 1'b0);
      run_op(2'b01, 3'd7, 1'b0, 8'hFF, 8'h00, 12'h000, 1'b0);
      run_op(2'b10, 3'd7, 1'b0, 8'hFF, 8'h80, 12'h000, 1'b0); // R6 -127 wrap down
      run_op(2'b10, 3'd7, 1'b1, 8'hFF, 8'h7F, 12'hFFF, 1'b0); // R6 +128 wrap up
      run_op(2'b00, 3'd3, 1'b0, 8'h40, 8'h00, 12'h000, 1'b0);
      run_op(2'b10, 3'd3, 1'b1, 8'h40, 8'h00, 12'h123, 1'b0); // R5 one, branch on one
      run_op(2'b10, 3'd3, 1'b0, 8'h40, 8'hFF, 12'h123, 1'b0); // R5 one, branch on zero
      run_op(2'b01, 3'd3, 1'b0, 8'h40, 8'h00, 12'h000, 1'b0);
      run_op(2'b10, 3'd3, 1'b0, 8'h40, 8'h10, 12'h800, 1'b0);
      run_op(2'b00, 3'd5, 1'b0, 8'h21, 8'h00, 12'h000, 1'b1); // R9
      run_op(2'b10, 3'd2, 1'b1, 8'h77, 8'h33, 12'h456, 1'b1); // R9

      // R10 reserved code
      @(negedge clk);
      w0 = wr_cnt; r0 = rd_cnt;
      op = 2'b11; start = 1'b1; addr = 8'h12;
      @(negedge clk);
      start = 1'b0;
      repeat (3) begin
         chk(busy === 1'b0, "R10 reserved not busy", busy, 0);
         @(negedge clk);
      end
      chk(wr_cnt == w0 && rd_cnt == r0, "R10 reserved no access",
          (wr_cnt - w0) + (rd_cnt - r0), 0);

      // random mix over the full range
      for (int n = 0; n < 400; n++) begin
         logic [1:0] ro;
         ro = 2'($urandom_range(0, 2));
         run_op(ro, 3'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                12'($urandom), ($urandom_range(0, 7) == 0));
      end

      // R4 whole data space matches the shadow copy
      for (int i = 0; i < 256; i++)
         chk(mem[i] === shadow[i], "R4 no stray byte change", mem[i], shadow[i]);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule